// File: doc/BRIEF.md
# Per-Channel DS0 Payload Conditioner

This block sits in the transmit path of a T1 framer, between the terminal-side payload source and the framing logic. Each incoming 8-bit PCM octet carries the number of the DS0 timeslot it belongs to. The block looks up that timeslot's 4-bit conditioning mode in a 24-entry table that the host writes. It then applies that mode to the octet. A mode can leave the octet unchanged, flip a chosen group of its bits, or replace it with a substitute code.

Some substitute codes are fixed. Others come from state: a host-written idle octet, an octet from an external pseudo-random generator, the timeslot number, or a repeating eight-step digital-milliwatt pattern. Each timeslot keeps its own milliwatt phase. The conditioned octet leaves one clock after it arrives and keeps its timeslot tag.

Top module: `ds0Conditioner`

## Requirements
- R1: When an octet is presented with `inValid` high, `outValid` goes high on the next clock, and `outTs` then equals the tag that came in. When `inValid` is low, `outValid` is low on the next clock.
- R2: Mode 0 passes the octet through unchanged. The spare modes 14 and 15 do the same.
- R3: Five modes flip bits with an XOR mask. Bit 7 is the MSB. The masks are:
  - mode 1: 0xFF (all bits)
  - mode 2: 0x55 (even positions 0, 2, 4, 6)
  - mode 3: 0xAA (odd positions 1, 3, 5, 7)
  - mode 4: 0x80 (MSB only)
  - mode 5: 0x7F (every bit except the MSB)
- R4: Three modes output a fixed octet. Mode 6 outputs 0x7F. Mode 8 outputs 0xFF. Mode 10 outputs 0x1A.
- R5: Mode 7 outputs binary 111 in bits 7..5 and the octet's 5-bit timeslot number in bits 4..0.
- R6: Mode 9 outputs the idle register. The idle register is 0xFF after reset. A write through `idleWe`/`idleCode` takes effect for octets presented after the write clock.
- R7: Mode 11 steps through 34,21,21,34,B4,A1,A1,B4 (hex). Mode 12 steps through 1E,0B,0B,1E,9E,8B,8B,9E (hex). Each timeslot has its own 3-bit phase. That phase advances by one after each octet of that timeslot that uses mode 11 or 12. Octets of other timeslots leave it unchanged.
- R8: Writing a timeslot's table entry resets that timeslot's milliwatt phase to step 0.
- R9: Mode 13 outputs the value on `prbsOctet` in the cycle the octet is presented. `prbsAdvance` is high in exactly the cycles where a valid octet uses mode 13.
- R10: Octets tagged 24 to 31 pass through unchanged. Table writes to addresses 24 to 31 are ignored.
- R11: After reset, `outValid` is low and every table entry is mode 0.
- R12: A table write changes only the addressed timeslot. The mode used for an octet is the one stored before any write in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Table write strobe |
| cfgAddr | input | 5 | Timeslot whose entry is written |
| cfgMode | input | 4 | Mode written to the entry |
| idleWe | input | 1 | Idle register write strobe |
| idleCode | input | 8 | Idle octet value |
| inValid | input | 1 | Input octet valid |
| inTs | input | 5 | Timeslot tag of the input octet |
| inData | input | 8 | Input PCM octet, bit 7 first on line |
| prbsOctet | input | 8 | Current pseudo-random octet |
| prbsAdvance | output | 1 | Tells the generator its octet was taken |
| outValid | output | 1 | Output octet valid |
| outTs | output | 5 | Timeslot tag of the output octet |
| outData | output | 8 | Conditioned octet |

## Verification
A corrupted table entry shows up on the very next octet of that timeslot, as a wrong mask or code on `outData` one clock after input. A wrong milliwatt phase counter is slower to expose. It is seen only on that channel's next milliwatt octet, and a counter off by four shows only as a flipped MSB. For this reason the bench runs each milliwatt channel through more than a full cycle, and interleaves two channels. A stuck or stray `prbsAdvance` is visible in the same cycle as its input octet, and a lost valid or tag shows one clock later.

// File: rtl/ds0CondPkg.sv
package ds0CondPkg;

  typedef enum logic [3:0] {
    MD_PASS     = 4'd0,
    MD_INV_ALL  = 4'd1,
    MD_INV_EVEN = 4'd2,
    MD_INV_ODD  = 4'd3,
    MD_INV_MSB  = 4'd4,
    MD_INV_LOW7 = 4'd5,
    MD_BUSY     = 4'd6,
    MD_BUSY_TS  = 4'd7,
    MD_VACANT   = 4'd8,
    MD_IDLE     = 4'd9,
    MD_MOOF     = 4'd10,
    MD_MW_A     = 4'd11,
    MD_MW_U     = 4'd12,
    MD_PRBS     = 4'd13,
    MD_SPARE14  = 4'd14,
    MD_SPARE15  = 4'd15
  } condMode_t;

  // Strobes from control to datapath for one octet slot.
  typedef struct packed {
    logic      take;
    condMode_t mode;
    logic [2:0] phase;
    logic [4:0] ts;
  } condStrb_t;

  // Milliwatt step: steps 1,2 (and 5,6) use the second base value,
  // steps 4..7 add the sign bit.
  function automatic logic [7:0] mwCode(input logic ulaw, input logic [2:0] ph);
    logic [6:0] base;
    if (ulaw) base = (ph[0] ^ ph[1]) ? 7'h0B : 7'h1E;
    else      base = (ph[0] ^ ph[1]) ? 7'h21 : 7'h34;
    return {ph[2], base};
  endfunction

endpackage

// File: rtl/ds0CondCtrl.sv
module ds0CondCtrl
  import ds0CondPkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int TS_W   = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [TS_W-1:0]   cfgAddr,
  input  logic [3:0]        cfgMode,
  input  logic              idleWe,
  input  logic [DATA_W-1:0] idleCode,
  input  logic              inValid,
  input  logic [TS_W-1:0]   inTs,
  output condStrb_t         strb,
  output logic [DATA_W-1:0] idleVal,
  output logic              prbsAdvance
);

  localparam logic [TS_W-1:0] LAST_TS = TS_W'(NUM_CH - 1);

  condMode_t  modeTab  [NUM_CH];
  logic [2:0] phaseTab [NUM_CH];

  logic      inRange;
  condMode_t curMode;
  logic [2:0] curPhase;
  logic      usesMw;

  assign inRange  = (inTs <= LAST_TS);
  assign curMode  = inRange ? modeTab[inTs]  : MD_PASS;
  assign curPhase = inRange ? phaseTab[inTs] : 3'd0;
  assign usesMw   = (curMode == MD_MW_A) || (curMode == MD_MW_U);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        modeTab[i]  <= MD_PASS;
        phaseTab[i] <= 3'd0;
      end
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (cfgWe && cfgAddr == TS_W'(i)) begin
          modeTab[i]  <= condMode_t'(cfgMode);
          phaseTab[i] <= 3'd0;
        end else if (inValid && usesMw && inTs == TS_W'(i)) begin
          phaseTab[i] <= phaseTab[i] + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       idleVal <= '1;
    else if (idleWe) idleVal <= idleCode;
  end

  always_comb begin
    strb.take  = inValid;
    strb.mode  = curMode;
    strb.phase = curPhase;
    strb.ts    = inTs[4:0];
  end

  assign prbsAdvance = inValid && (curMode == MD_PRBS);

endmodule

// File: rtl/ds0CondPath.sv
module ds0CondPath
  import ds0CondPkg::*;
#(
  parameter int TS_W   = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  condStrb_t         strb,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] idleVal,
  input  logic [DATA_W-1:0] prbsOctet,
  output logic              outValid,
  output logic [TS_W-1:0]   outTs,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] nextData;

  always_comb begin
    unique case (strb.mode)
      MD_INV_ALL:  nextData = inData ^ 8'hFF;
      MD_INV_EVEN: nextData = inData ^ 8'h55;
      MD_INV_ODD:  nextData = inData ^ 8'hAA;
      MD_INV_MSB:  nextData = inData ^ 8'h80;
      MD_INV_LOW7: nextData = inData ^ 8'h7F;
      MD_BUSY:     nextData = 8'h7F;
      MD_BUSY_TS:  nextData = {3'b111, strb.ts};
      MD_VACANT:   nextData = 8'hFF;
      MD_IDLE:     nextData = idleVal;
      MD_MOOF:     nextData = 8'h1A;
      MD_MW_A:     nextData = mwCode(1'b0, strb.phase);
      MD_MW_U:     nextData = mwCode(1'b1, strb.phase);
      MD_PRBS:     nextData = prbsOctet;
      default:     nextData = inData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outTs    <= '0;
      outData  <= '0;
    end else begin
      outValid <= strb.take;
      if (strb.take) begin
        outTs   <= TS_W'(strb.ts);
        outData <= nextData;
      end
    end
  end

endmodule

// File: rtl/ds0Conditioner.sv
module ds0Conditioner
  import ds0CondPkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int TS_W   = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [TS_W-1:0]   cfgAddr,
  input  logic [3:0]        cfgMode,
  input  logic              idleWe,
  input  logic [DATA_W-1:0] idleCode,
  input  logic              inValid,
  input  logic [TS_W-1:0]   inTs,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] prbsOctet,
  output logic              prbsAdvance,
  output logic              outValid,
  output logic [TS_W-1:0]   outTs,
  output logic [DATA_W-1:0] outData
);

  condStrb_t         strb;
  logic [DATA_W-1:0] idleVal;

  ds0CondCtrl #(.NUM_CH(NUM_CH), .TS_W(TS_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgMode(cfgMode),
    .idleWe(idleWe), .idleCode(idleCode),
    .inValid(inValid), .inTs(inTs),
    .strb(strb), .idleVal(idleVal), .prbsAdvance(prbsAdvance)
  );

  ds0CondPath #(.TS_W(TS_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN),
    .strb(strb), .inData(inData), .idleVal(idleVal), .prbsOctet(prbsOctet),
    .outValid(outValid), .outTs(outTs), .outData(outData)
  );

endmodule

// File: rtl/ds0CondChk.sv
module ds0CondChk
  import ds0CondPkg::*;
#(
  parameter int TS_W   = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [TS_W-1:0]   inTs,
  input logic              prbsAdvance,
  input logic              outValid,
  input logic [TS_W-1:0]   outTs,
  input logic [DATA_W-1:0] outData,
  input condStrb_t         strb
);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R1
  tag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outTs == $past(inTs)));

  // R4
  busy_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && strb.mode == MD_BUSY) |=> (outData == 8'h7F));

  // R4
  vacant_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && strb.mode == MD_VACANT) |=> (outData == 8'hFF));

  // R5
  busy_ts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && strb.mode == MD_BUSY_TS) |=> (outData[7:5] == 3'b111));

  // R9
  prbs_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    prbsAdvance |-> inValid);

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !outValid);

endmodule

bind ds0Conditioner ds0CondChk #(.TS_W(TS_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inTs(inTs),
  .prbsAdvance(prbsAdvance), .outValid(outValid), .outTs(outTs),
  .outData(outData), .strb(strb)
);

// File: tb/sim_ds0Conditioner.sv
module sim_ds0Conditioner;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [4:0] cfgAddr = '0;
  logic [3:0] cfgMode = '0;
  logic       idleWe = 1'b0;
  logic [7:0] idleCode = '0;
  logic       inValid = 1'b0;
  logic [4:0] inTs = '0;
  logic [7:0] inData = '0;
  logic [7:0] prbsOctet = '0;
  logic       prbsAdvance;
  logic       outValid;
  logic [4:0] outTs;
  logic [7:0] outData;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [3:0] mModes [24];
  logic [2:0] mPhase [24];
  logic [7:0] mIdle;
  logic [7:0] aTab [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
  logic [7:0] uTab [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};

  always #2 clk = ~clk;

  ds0Conditioner u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgMode(cfgMode),
    .idleWe(idleWe), .idleCode(idleCode), .inValid(inValid), .inTs(inTs),
    .inData(inData), .prbsOctet(prbsOctet), .prbsAdvance(prbsAdvance),
    .outValid(outValid), .outTs(outTs), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input int m, input int ts);
    if (ts >= 24) return "R10";
    case (m)
      0, 14, 15:  return "R2";
      1, 2, 3, 4, 5: return "R3";
      6, 8, 10:   return "R4";
      7:          return "R5";
      9:          return "R6";
      11, 12:     return "R7";
      default:    return "R9";
    endcase
  endfunction

  function automatic logic [7:0] expOct(input int m, input logic [4:0] ts,
                                        input logic [7:0] d, input logic [7:0] pr,
                                        input logic [2:0] ph);
    case (m)
      1:  return ~d;
      2:  return d ^ 8'h55;
      3:  return d ^ 8'hAA;
      4:  return d ^ 8'h80;
      5:  return d ^ 8'h7F;
      6:  return 8'h7F;
      7:  return 8'hE0 | {3'b000, ts};
      8:  return 8'hFF;
      9:  return mIdle;
      10: return 8'h1A;
      11: return aTab[ph];
      12: return uTab[ph];
      13: return pr;
      default: return d;
    endcase
  endfunction

  task automatic writeCfg(input int a, input int m);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 5'(a); cfgMode = 4'(m);
    @(posedge clk); #1;
    cfgWe = 1'b0;
    if (a < 24) begin
      mModes[a] = 4'(m);
      mPhase[a] = 3'd0;
    end
  endtask

  task automatic sendOct(input int ts, input logic [7:0] d, input logic [7:0] pr);
    int m;
    logic [7:0] e;
    string r;
    m = (ts < 24) ? int'(mModes[ts]) : 0;
    e = expOct(m, 5'(ts), d, pr, (ts < 24) ? mPhase[ts] : 3'd0);
    r = reqOf(m, ts);
    @(negedge clk);
    inValid = 1'b1; inTs = 5'(ts); inData = d; prbsOctet = pr;
    #1;
    check(prbsAdvance == (m == 13), "R9 prbsAdvance", int'(prbsAdvance), int'(m == 13));
    @(posedge clk); #1;
    inValid = 1'b0;
    if (ts < 24 && (m == 11 || m == 12)) mPhase[ts] = mPhase[ts] + 3'd1;
    check(outValid && outTs == 5'(ts), "R1 valid/tag", int'({outValid, outTs}), int'({1'b1, 5'(ts)}));
    check(outData == e, r, int'(outData), int'(e));
  endtask

  initial begin
    #400000;
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 24; i++) begin mModes[i] = 4'd0; mPhase[i] = 3'd0; end
    mIdle = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 1'b0, "R11 outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(outValid == 1'b0, "R11 outValid after reset", int'(outValid), 0);
    // R11: table starts in pass mode for every timeslot
    for (int t = 0; t < 24; t++) sendOct(t, 8'(t * 11 + 3), 8'h00);

    // Sweep: every mode on every timeslot; R12 per-entry independence via model
    for (int m = 0; m < 16; m++) begin
      for (int t = 0; t < 24; t++) begin
        writeCfg(t, m);
        sendOct(t, 8'h00, 8'(t * 7 + m));
        sendOct(t, 8'hA5, 8'(t * 13 + 1));
        sendOct(t, 8'h3C, 8'hC3);
        sendOct(t, 8'(t * 9 + m), 8'(m * 17));
      end
    end

    // R12: other channels keep their mode after a write (all now mode 15)
    writeCfg(4, 1);
    sendOct(5, 8'h12, 8'h00);
    sendOct(4, 8'h12, 8'h00);

    // R6: idle register write
    writeCfg(9, 9);
    sendOct(9, 8'h00, 8'h00);
    @(negedge clk); idleWe = 1'b1; idleCode = 8'h5A;
    @(posedge clk); #1; idleWe = 1'b0; mIdle = 8'h5A;
    sendOct(9, 8'h00, 8'h00);

    // R7: two channels interleaved, more than a full cycle each
    writeCfg(2, 11);
    writeCfg(17, 12);
    for (int k = 0; k < 11; k++) begin
      sendOct(2, 8'h00, 8'h00);
      sendOct(17, 8'h00, 8'h00);
      if (k % 3 == 0) sendOct(6, 8'h44, 8'h00);
    end
    // R8: rewrite resets phase
    writeCfg(2, 11);
    sendOct(2, 8'h00, 8'h00);
    sendOct(2, 8'h00, 8'h00);

    // R9: PRBS value follows input each octet
    writeCfg(20, 13);
    for (int k = 0; k < 5; k++) sendOct(20, 8'h99, 8'(k * 37 + 5));

    // R10: out-of-range tags pass, writes there ignored
    writeCfg(25, 1);
    for (int t = 24; t < 32; t++) sendOct(t, 8'(t + 100), 8'h00);
    sendOct(0, 8'h21, 8'h00);

    // R1: no input, no output
    @(negedge clk); inValid = 1'b0;
    @(posedge clk); #1;
    check(outValid == 1'b0, "R1 idle cycle", int'(outValid), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule